// File: doc/BRIEF.md
# Pseudo gray-scale error-diffusion quantizer

This block sits between a video source and a flat-panel driver. It accepts three 8-bit color samples per dot clock and reduces each one to 3, 4, 5 or 6 significant bits, according to a 4-bit mode code. The block keeps the truncation residue of each channel and adds it to the next pixel on the same line. A frame parity bit adds half an output step on alternate frames. Together these let a narrow driver show more apparent gray levels than its width allows.

The result leaves the block MSB-aligned on an 8-bit bus, and the bits below the active LSB are held at zero. Horizontal sync, vertical sync, data-valid and two panel control bits pass through a two-stage delay, so they leave aligned with the pixel they arrived with. An active-low bypass input sends the raw samples through with the same latency. The block has no notion of line length. Lines and frames are delimited only by the syncs and by data-valid.

Top module: `pseudo_gray_quant`

## Requirements
- R1: The output for a pixel presented at rising edge t appears on the data outputs after rising edge t+2, with no extra delay and no bubbles.
- R2: The outputs `hs_n_out`, `vs_n_out`, `de_out` and `ctl_out` equal the values of their inputs sampled two rising edges earlier.
- R3: Mode codes 0, 8, 12 and 15 give 3 output bits with bit 5 as LSB. Codes 1, 5, 9 and 13 give 4 bits with bit 4 as LSB. Codes 6 and 14 give 5 bits with bit 3 as LSB. Codes 3 and 7 give 6 bits with bit 2 as LSB. Every bit below the LSB is 0 whenever bypass is not active.
- R4: For an active pixel (hs_n high, de high, bypass inactive), sum = pixel + carry + offset. The output is that sum with its low bits below the LSB cleared. The new carry is those low bits.
- R5: A pixel with hs_n low or de low uses a carry of zero and leaves a carry of zero for the next pixel.
- R6: A frame parity bit starts at 0 and toggles at each sampled high-to-low transition of `vs_n_in`. The parity takes effect for the pixel sampled in the same cycle. While it is 1, the offset is half an output step (1 << (LSB-1)). Otherwise the offset is 0.
- R7: A pixel sampled with `pass_n` low appears unchanged on the output two edges later. It also leaves a carry of zero.
- R8: While `rst_n` is low at a rising edge, the data outputs, `de_out` and `ctl_out` go to 0, the syncs go to 1, and the carries and the parity clear.
- R9: A sum above 255 saturates to 255 before truncation. The carry is then taken from 255.
- R10: Mode codes 2, 4, 10 and 11 behave as 6-bit output (LSB at bit 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 4 | Output depth code, bit 0 is LSB |
| pass_n | input | 1 | Active-low bypass, sampled per pixel |
| red_in | input | 8 | Red sample, bit 7 MSB |
| grn_in | input | 8 | Green sample |
| blu_in | input | 8 | Blue sample |
| hs_n_in | input | 1 | Horizontal sync, active low |
| vs_n_in | input | 1 | Vertical sync, active low |
| de_in | input | 1 | Data valid, high on active pixels |
| ctl_in | input | 2 | Panel control bits |
| red_out | output | 8 | Quantized red, MSB-aligned |
| grn_out | output | 8 | Quantized green |
| blu_out | output | 8 | Quantized blue |
| hs_n_out | output | 1 | Delayed horizontal sync |
| vs_n_out | output | 1 | Delayed vertical sync |
| de_out | output | 1 | Delayed data valid |
| ctl_out | output | 2 | Delayed control bits |

## Verification
A corrupted carry register shows up at the ports on the next active pixel of the same line. Its output step moves by one LSB against a model that tracks the residue independently, so a stale carry across a sync or a blank shows within one pixel of the line start. A wrong frame parity shifts every half-step boundary of the following frame, which shows on the first mid-range pixel after the falling vertical sync. A slip in the sync delay misaligns every control output from its pixel at once.

// File: rtl/pgq_pkg.sv
// Shared widths and mode decoding for the pseudo gray-scale quantizer.
// Assumes 8-bit color samples; the mode table maps a 4-bit code to the
// bit position of the output LSB.
package pgq_pkg;
    localparam int PIX_W  = 8;
    localparam int LSB_W  = $clog2(PIX_W);
    localparam int MODE_W = 4;
    localparam int CTL_W  = 2;

    // Position of the output LSB for a mode code; unlisted codes give 6 bits.
    function automatic logic [LSB_W-1:0] lsb_of_mode(input logic [MODE_W-1:0] m);
        case (m)
            4'h0, 4'h8, 4'hC, 4'hF: return LSB_W'(5);
            4'h1, 4'h5, 4'h9, 4'hD: return LSB_W'(4);
            4'h6, 4'hE:             return LSB_W'(3);
            default:                return LSB_W'(2);
        endcase
    endfunction

    // Mask of the bits kept at and above the LSB position.
    function automatic logic [PIX_W-1:0] keep_mask(input logic [LSB_W-1:0] lsb);
        logic [PIX_W-1:0] one;
        one = {{(PIX_W-1){1'b0}}, 1'b1};
        return ~((one << lsb) - one);
    endfunction
endpackage

// File: rtl/pgq_delay.sv
// Generic register delay line with a per-bit reset value.
// Assumes D >= 1; every stage resets synchronously when rst_n is low.
module pgq_delay #(
    parameter int             W       = 5,
    parameter int             D       = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [D];

    generate
        for (genvar i = 0; i < D; i++) begin : g_stage
            // Shift one stage of the line per clock.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= RST_VAL;
                else        stg[i] <= (i == 0) ? din : stg[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign dout = stg[D-1];
endmodule

// File: rtl/pgq_frame_phase.sv
// Frame parity tracker: toggles on every sampled falling edge of the
// active-low vertical sync. Assumes vs_n is synchronous to clk.
module pgq_frame_phase (
    input  logic clk,
    input  logic rst_n,
    input  logic vs_n,
    output logic parity
);
    logic vs_q;
    logic fall;

    assign fall = vs_q & ~vs_n;

    // Remember last sync level and flip parity on a falling transition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vs_q   <= 1'b1;
            parity <= 1'b0;
        end else begin
            vs_q   <= vs_n;
            parity <= parity ^ fall;
        end
    end

    AST_PARITY_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> parity != $past(parity)); // R6
    AST_PARITY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fall |=> $stable(parity)); // R6
endmodule

// File: rtl/pgq_channel.sv
// One color channel: adds the carried residue and the frame offset,
// saturates, truncates to the selected depth and registers the result.
// Assumes inputs come from the first pipeline stage; this is stage two.
module pgq_channel
    import pgq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIX_W-1:0] pix,
    input  logic [LSB_W-1:0] lsb,
    input  logic             bypass,
    input  logic             active,
    input  logic             parity,
    output logic [PIX_W-1:0] q
);
    logic [PIX_W-1:0] err_q;
    logic [PIX_W-1:0] mask;
    logic [PIX_W-1:0] half;
    logic [PIX_W-1:0] carry;
    logic [PIX_W:0]   sum;
    logic [PIX_W-1:0] sat;
    logic [LSB_W-1:0] lsb_q;
    logic             byp_q;
    logic             use_err;

    assign use_err = active & ~bypass;

    // Form the rounded, saturated value for this pixel.
    always_comb begin
        mask  = keep_mask(lsb);
        half  = {{(PIX_W-1){1'b0}}, 1'b1} << (lsb - LSB_W'(1));
        carry = use_err ? err_q : '0;
        sum   = {1'b0, pix} + {1'b0, carry} + (parity ? {1'b0, half} : '0);
        sat   = sum[PIX_W] ? '1 : sum[PIX_W-1:0];
    end

    // Register the output and the residue that feeds the next pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= '0;
            err_q <= '0;
            lsb_q <= '0;
            byp_q <= 1'b0;
        end else begin
            q     <= bypass ? pix : (sat & mask);
            err_q <= use_err ? (sat & ~mask) : '0;
            lsb_q <= lsb;
            byp_q <= bypass;
        end
    end

    AST_LOW_BITS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !byp_q |-> (q & ~keep_mask(lsb_q)) == '0); // R3
    AST_RESIDUE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q & keep_mask(lsb_q)) == '0); // R4
    AST_CARRY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !use_err |=> err_q == '0); // R5
    AST_PASS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |=> q == $past(pix)); // R7
endmodule

// File: rtl/pseudo_gray_quant.sv
// Top of the pseudo gray-scale quantizer. Stage one registers pixels and
// controls; stage two quantizes each channel. Syncs, data-valid and the
// control bits are delayed two cycles to stay aligned with the data.
// Assumes all inputs are synchronous to clk; no fixed line length.
module pseudo_gray_quant
    import pgq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic              pass_n,
    input  logic [PIX_W-1:0]  red_in,
    input  logic [PIX_W-1:0]  grn_in,
    input  logic [PIX_W-1:0]  blu_in,
    input  logic              hs_n_in,
    input  logic              vs_n_in,
    input  logic              de_in,
    input  logic [CTL_W-1:0]  ctl_in,
    output logic [PIX_W-1:0]  red_out,
    output logic [PIX_W-1:0]  grn_out,
    output logic [PIX_W-1:0]  blu_out,
    output logic              hs_n_out,
    output logic              vs_n_out,
    output logic              de_out,
    output logic [CTL_W-1:0]  ctl_out
);
    localparam int N_CH   = 3;
    localparam int PIXS_W = N_CH * PIX_W;
    localparam int STG_W  = PIXS_W + MODE_W + 3;
    localparam int SY_W   = 3 + CTL_W;
    localparam int LAT    = 2;
    localparam logic [STG_W-1:0] STG_RST = {{(PIXS_W+MODE_W){1'b0}}, 1'b1, 1'b1, 1'b0};
    localparam logic [SY_W-1:0]  SY_RST  = {1'b1, 1'b1, 1'b0, {CTL_W{1'b0}}};

    logic [STG_W-1:0]  s1;
    logic [PIXS_W-1:0] s1_pix;
    logic [MODE_W-1:0] s1_mode;
    logic              s1_pass_n;
    logic              s1_hs_n;
    logic              s1_de;
    logic [PIXS_W-1:0] q_all;
    logic              parity;
    logic [1:0]        warm;

    // Stage one: capture pixel, mode and per-pixel controls.
    pgq_delay #(.W(STG_W), .D(1), .RST_VAL(STG_RST)) u_stage1 (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({blu_in, grn_in, red_in, mode_sel, pass_n, hs_n_in, de_in}),
        .dout (s1)
    );
    assign {s1_pix, s1_mode, s1_pass_n, s1_hs_n, s1_de} = s1;

    // Frame parity from the raw vertical sync, aligned with stage one.
    pgq_frame_phase u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .vs_n  (vs_n_in),
        .parity(parity)
    );

    // Sync and control path matching the data latency.
    pgq_delay #(.W(SY_W), .D(LAT), .RST_VAL(SY_RST)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({hs_n_in, vs_n_in, de_in, ctl_in}),
        .dout ({hs_n_out, vs_n_out, de_out, ctl_out})
    );

    generate
        for (genvar c = 0; c < N_CH; c++) begin : g_ch
            pgq_channel u_ch (
                .clk   (clk),
                .rst_n (rst_n),
                .pix   (s1_pix[c*PIX_W +: PIX_W]),
                .lsb   (lsb_of_mode(s1_mode)),
                .bypass(~s1_pass_n),
                .active(s1_hs_n & s1_de),
                .parity(parity),
                .q     (q_all[c*PIX_W +: PIX_W])
            );
        end
    endgenerate

    assign red_out = q_all[0*PIX_W +: PIX_W];
    assign grn_out = q_all[1*PIX_W +: PIX_W];
    assign blu_out = q_all[2*PIX_W +: PIX_W];

    // Count edges since reset so history-based checks start valid.
    always_ff @(posedge clk) begin
        if (!rst_n)            warm <= 2'd0;
        else if (warm != 2'd2) warm <= warm + 2'd1;
    end

    AST_SYNC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd2) |-> {hs_n_out, vs_n_out, de_out, ctl_out}
                           == $past({hs_n_in, vs_n_in, de_in, ctl_in}, 2)); // R2
    AST_BYPASS_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        ((warm == 2'd2) && !$past(pass_n, 2)) |->
            {blu_out, grn_out, red_out} == $past({blu_in, grn_in, red_in}, 2)); // R7
endmodule

// File: tb/sim_pseudo_gray_quant.sv
module sim_pseudo_gray_quant;
    typedef struct {
        logic [7:0] r, g, b;
        logic [4:0] sy;
        int         lsb;
        bit         byp;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] mode_sel = 4'h0;
    logic       pass_n = 1'b1;
    logic [7:0] red_in = 8'h0, grn_in = 8'h0, blu_in = 8'h0;
    logic       hs_n_in = 1'b1, vs_n_in = 1'b1, de_in = 1'b0;
    logic [1:0] ctl_in = 2'b00;
    logic [7:0] red_out, grn_out, blu_out;
    logic       hs_n_out, vs_n_out, de_out;
    logic [1:0] ctl_out;

    int checks = 0;
    int errors = 0;
    exp_t sb[$];
    int   err_m[3];
    bit   par_m = 1'b0;
    bit   vs_prev = 1'b1;

    always #4 clk = ~clk;

    pseudo_gray_quant u0 (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .pass_n(pass_n),
        .red_in(red_in), .grn_in(grn_in), .blu_in(blu_in),
        .hs_n_in(hs_n_in), .vs_n_in(vs_n_in), .de_in(de_in), .ctl_in(ctl_in),
        .red_out(red_out), .grn_out(grn_out), .blu_out(blu_out),
        .hs_n_out(hs_n_out), .vs_n_out(vs_n_out), .de_out(de_out), .ctl_out(ctl_out)
    );

    function automatic int lsb_model(input logic [3:0] m);
        case (m)
            4'h0, 4'h8, 4'hC, 4'hF: return 5;
            4'h1, 4'h5, 4'h9, 4'hD: return 4;
            4'h6, 4'hE:             return 3;
            default:                return 2;
        endcase
    endfunction

    function automatic logic [7:0] model_ch(input int ch, input int pix, input int lsb,
                                            input bit byp, input bit act);
        int step, sum, low;
        step = 1 << lsb;
        if (byp) begin
            err_m[ch] = 0;
            return pix[7:0];
        end
        sum = pix + (act ? err_m[ch] : 0) + (par_m ? step / 2 : 0);
        if (sum > 255) sum = 255;
        low = sum % step;
        err_m[ch] = act ? low : 0;
        return 8'(sum - low);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Driver: apply one pixel and push its expected result.
    task automatic drive(input logic [7:0] r, g, b, input logic [3:0] m, input bit pn,
                         input bit hs, vs, de, input logic [1:0] ctl, input string tag);
        exp_t e;
        bit act;
        mode_sel = m; pass_n = pn; red_in = r; grn_in = g; blu_in = b;
        hs_n_in = hs; vs_n_in = vs; de_in = de; ctl_in = ctl;
        if (vs_prev && !vs) par_m = ~par_m;
        vs_prev = vs;
        act = hs && de;
        e.lsb = lsb_model(m);
        e.byp = !pn;
        e.r = model_ch(0, r, e.lsb, !pn, act);
        e.g = model_ch(1, g, e.lsb, !pn, act);
        e.b = model_ch(2, b, e.lsb, !pn, act);
        e.sy = {hs, vs, de, ctl};
        e.tag = tag;
        sb.push_back(e);
        @(posedge clk); #2;
    endtask

    task automatic line(input logic [3:0] m, input int n, input string tag);
        drive(8'h0, 8'h0, 8'h0, m, 1'b1, 1'b0, 1'b1, 1'b0, 2'b01, tag);
        for (int i = 0; i < n; i++)
            drive(8'($urandom), 8'($urandom), 8'($urandom), m, 1'b1, 1'b1, 1'b1, 1'b1, 2'(i), tag);
    endtask

    // Monitor: pop and compare as results leave the pipeline.
    always @(negedge clk) begin
        if (rst_n && sb.size() >= 3) begin
            exp_t e;
            logic [7:0] msk;
            e = sb.pop_front();
            check(e.tag, {8'h0, blu_out, grn_out, red_out}, {8'h0, e.b, e.g, e.r}, "pixel");
            check("R2", {27'h0, hs_n_out, vs_n_out, de_out, ctl_out}, {27'h0, e.sy}, "sync");
            if (!e.byp) begin
                msk = 8'((1 << e.lsb) - 1);
                check("R3", {8'h0, blu_out & msk, grn_out & msk, red_out & msk}, 32'h0, "low bits");
            end
        end
    end

    initial begin
        #1_600_000;
        errors++;
        $display("FAIL R1 watchdog expired actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: reset state at the ports
        check("R8", {8'h0, blu_out, grn_out, red_out}, 32'h0, "reset data");
        check("R8", {27'h0, hs_n_out, vs_n_out, de_out, ctl_out}, {27'h0, 5'b11000}, "reset sync");
        @(posedge clk); #2;
        rst_n = 1'b1;
        // R1: plain stream in 6-bit mode
        line(4'h3, 10, "R1");
        // R3 / R10: every mode code
        for (int m = 0; m < 16; m++)
            line(4'(m), 6, (m == 2 || m == 4 || m == 10 || m == 11) ? "R10" : "R3");
        // R4: constant run accumulates residue
        drive(8'h0, 8'h0, 8'h0, 4'h0, 1'b1, 1'b0, 1'b1, 1'b0, 2'b00, "R4");
        for (int i = 0; i < 8; i++) drive(8'd100, 8'd37, 8'd201, 4'h0, 1'b1, 1'b1, 1'b1, 1'b1, 2'b10, "R4");
        // R9: saturation near full scale
        for (int i = 0; i < 6; i++) drive(8'(250 + i), 8'd255, 8'd254, 4'h1, 1'b1, 1'b1, 1'b1, 1'b1, 2'b11, "R9");
        // R5: blank mid-line, then a sync mid-line
        drive(8'd100, 8'd100, 8'd100, 4'h0, 1'b1, 1'b1, 1'b1, 1'b1, 2'b00, "R5");
        drive(8'd0, 8'd0, 8'd0, 4'h0, 1'b1, 1'b1, 1'b1, 1'b0, 2'b00, "R5");
        for (int i = 0; i < 3; i++) drive(8'd100, 8'd60, 8'd20, 4'h0, 1'b1, 1'b1, 1'b1, 1'b1, 2'b01, "R5");
        drive(8'd90, 8'd90, 8'd90, 4'h0, 1'b1, 1'b0, 1'b1, 1'b1, 2'b01, "R5");
        for (int i = 0; i < 3; i++) drive(8'd100, 8'd60, 8'd20, 4'h0, 1'b1, 1'b1, 1'b1, 1'b1, 2'b10, "R5");
        // R6: vertical sync falls, new frame parity
        drive(8'd0, 8'd0, 8'd0, 4'h1, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, "R6");
        drive(8'd0, 8'd0, 8'd0, 4'h1, 1'b1, 1'b0, 1'b1, 1'b0, 2'b00, "R6");
        for (int i = 0; i < 6; i++) drive(8'(8 * i + 7), 8'd120, 8'd77, 4'h1, 1'b1, 1'b1, 1'b1, 1'b1, 2'b01, "R6");
        line(4'h6, 6, "R6");
        drive(8'd0, 8'd0, 8'd0, 4'h1, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, "R6");
        drive(8'd0, 8'd0, 8'd0, 4'h1, 1'b1, 1'b0, 1'b1, 1'b0, 2'b00, "R6");
        for (int i = 0; i < 4; i++) drive(8'd40, 8'd41, 8'd42, 4'h1, 1'b1, 1'b1, 1'b1, 1'b1, 2'b11, "R6");
        // R7: bypass interleaved with quantized pixels
        for (int i = 0; i < 8; i++)
            drive(8'(13 * i + 3), 8'(29 * i + 1), 8'(200 - i), 4'h0, 1'(i % 3 == 0) ? 1'b1 : 1'b0,
                  1'b1, 1'b1, 1'b1, 2'(i), "R7");
        // R1: flush the pipeline with blanking
        for (int i = 0; i < 3; i++) drive(8'h0, 8'h0, 8'h0, 4'h3, 1'b1, 1'b1, 1'b1, 1'b0, 2'b00, "R1");
        @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule